// File: doc/BRIEF.md
# Cartridge Serial Unlock and Bank Mapper

This block sits on the cartridge side of an 8-bit processor bus and guards a ROM behind a serial handshake. After reset it is locked and the ROM stays invisible. The host proves itself by writing a fixed key one bit at a time on data bit 2. Each key character takes nine writes: its eight bits, most significant first, and then a zero. The block then answers with a fixed byte, one bit per read, which it drives on data bit 1. The eighth answer read opens the ROM.

Once open, the block turns the 32K processor window 6000h-DFFFh into a flat ROM address. The window is shifted down by 6000h and split into two 16K halves. The upper half always follows a bank register that is loaded by writes to C000h-DFFFh. The lower half is bank 0, unless the dual-bank variant is built; in that variant a second register, loaded by writes to 8000h-9FFFh, selects it. A wrong key bit leaves the block locked until the next reset. Each bus access is one clock cycle with the active-low chip enable asserted.

Top module: `cart_guard_mapper`

## Requirements
- R1: After reset the block is locked: rom_en and resp_valid stay 0 on every access, and both bank registers are 0.
- R2: While locked, each write in 6000h-7FFFh delivers the next key bit on cpu_wdata[2]. Character c of KEY (first character in the top byte) is sent as its bits 7 down to 0, then a 0, for 9*KEY_LEN writes. The other data bits are ignored, and reads during this phase give no response.
- R3: A key bit that differs from the expected value locks the block until reset. No response bit and no ROM enable follow, whatever is written or read afterwards.
- R4: After the final key write, the next eight reads in 6000h-7FFFh each assert resp_valid. resp_bit carries RESP_BYTE (default 47h), most significant bit first, and is meant for data bit 1.
- R5: rom_en is 0 until the eighth response read has completed. After that it is 1 exactly on reads with the chip enable low and an address in 6000h-DFFFh.
- R6: rom_addr = bank*4000h + ((cpu_addr - 6000h) mod 4000h). Addresses 6000h-9FFFh use the lower bank and A000h-DFFFh use the upper bank.
- R7: A write in C000h-DFFFh loads the upper bank from cpu_wdata[BANK_W-1:0], where BANK_W = ROM_AW-14. Writes in A000h-BFFFh leave it unchanged.
- R8: With DUAL_BANK=1, a write in 8000h-9FFFh loads the lower bank. With DUAL_BANK=0, the lower bank stays 0.
- R9: A cycle with cpu_ce_n high is not an access: it advances no key, response or bank state and drives neither rom_en nor resp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one access per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_ce_n | input | 1 | Active-low cartridge enable (6000h-DFFFh, phi2 high) |
| rom_addr | output | ROM_AW | Flat ROM address |
| rom_en | output | 1 | ROM output enable |
| resp_valid | output | 1 | Response bit is being driven this cycle |
| resp_bit | output | 1 | Response bit for data bit 1 |

## Verification
The assertions check on every cycle that the ROM enable never appears unless the block is open. They also check that a response is only given in the response phase and that a lock failure sticks. Further cycle checks cover the step from key end to response and from last response to open, bank loading from C000h-DFFFh writes, the preservation of the low address bits, and the idle behaviour with the chip enable high. Only the bench's scenarios can show the full picture. These cover the exact key bit order including the trailing zeros, the response byte value, the bank arithmetic across both halves, and the difference between the two bank variants.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    ST_KEY  = 2'd0,
    ST_RESP = 2'd1,
    ST_OPEN = 2'd2,
    ST_DEAD = 2'd3
  } lock_state_t;

  // Guard region for the handshake: 6000h-7FFFh.
  function automatic logic in_guard(input logic [15:0] a);
    return a[15:13] == 3'b011;
  endfunction

  // Full ROM window: 6000h-DFFFh.
  function automatic logic in_window(input logic [15:0] a);
    return (a >= 16'h6000) && (a < 16'hE000);
  endfunction

  // Window offset after removing the 6000h base (0..7FFFh).
  function automatic logic [14:0] win_offset(input logic [15:0] a);
    logic [15:0] d;
    d = a - 16'h6000;
    return d[14:0];
  endfunction

endpackage

// File: rtl/cart_key_seq.sv
module cart_key_seq
  import cart_map_pkg::*;
#(
  parameter int          KEY_LEN   = 15,
  parameter logic [8*KEY_LEN-1:0] KEY = "UNLOCK SEQUENCE",
  parameter logic [7:0]  RESP_BYTE = 8'h47
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic        key_din,
  output lock_state_t state,
  output logic        resp_valid,
  output logic        resp_bit,
  output logic        mismatch_evt,
  output logic        key_done_evt,
  output logic        resp_last_evt
);
  localparam int CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  logic [CW-1:0] char_idx;
  logic [3:0]    bit_idx;
  logic [2:0]    rd_idx;
  logic [7:0]    cur_char;
  logic          exp_bit;
  logic          last_char;
  logic          key_bit_evt;

  always_comb begin
    cur_char = KEY[(KEY_LEN - 1 - int'(char_idx)) * 8 +: 8];
    exp_bit  = (bit_idx == 4'd8) ? 1'b0 : cur_char[3'd7 - bit_idx[2:0]];
  end

  assign last_char     = (char_idx == CW'(KEY_LEN - 1));
  assign key_bit_evt   = (state == ST_KEY) && wr_stb;
  assign mismatch_evt  = key_bit_evt && (key_din != exp_bit);
  assign key_done_evt  = key_bit_evt && !mismatch_evt && (bit_idx == 4'd8) && last_char;
  assign resp_valid    = (state == ST_RESP) && rd_stb;
  assign resp_last_evt = resp_valid && (rd_idx == 3'd7);
  assign resp_bit      = resp_valid && RESP_BYTE[3'd7 - rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_KEY;
      char_idx <= '0;
      bit_idx  <= '0;
      rd_idx   <= '0;
    end else begin
      case (state)
        ST_KEY: if (wr_stb) begin
          if (key_din != exp_bit) begin
            state <= ST_DEAD;
          end else if (bit_idx == 4'd8) begin
            bit_idx <= '0;
            if (last_char) state <= ST_RESP;
            else           char_idx <= char_idx + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_RESP: if (rd_stb) begin
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == 3'd7) state <= ST_OPEN;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cart_bank_file.sv
module cart_bank_file #(
  parameter int BANK_W    = 3,
  parameter bit DUAL_BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [2:0]        addr_top,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] hi_bank,
  output logic [BANK_W-1:0] lo_bank
);
  logic hi_load;
  assign hi_load = wr_stb && (addr_top == 3'b110);

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_bank <= '0;
    else if (hi_load) hi_bank <= wdata;
  end

  generate
    if (DUAL_BANK) begin : g_dual
      logic lo_load;
      logic [BANK_W-1:0] lo_q;
      assign lo_load = wr_stb && (addr_top == 3'b100);
      always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (lo_load) lo_q <= wdata;
      end
      assign lo_bank = lo_q;
    end else begin : g_fixed
      assign lo_bank = '0;
    end
  endgenerate

endmodule

// File: rtl/cart_addr_xlat.sv
module cart_addr_xlat
  import cart_map_pkg::*;
#(
  parameter int ROM_AW = 17
) (
  input  logic [15:0]        addr,
  input  logic               rd_stb,
  input  logic               open,
  input  logic [ROM_AW-15:0] hi_bank,
  input  logic [ROM_AW-15:0] lo_bank,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               rom_en
);
  logic [14:0]        off;
  logic [ROM_AW-15:0] bank;

  always_comb begin
    off      = win_offset(addr);
    bank     = off[14] ? hi_bank : lo_bank;
    rom_addr = {bank, off[13:0]};
    rom_en   = rd_stb && open && in_window(addr);
  end

endmodule

// File: rtl/cart_guard_mapper.sv
module cart_guard_mapper
  import cart_map_pkg::*;
#(
  parameter int          ROM_AW    = 17,
  parameter bit          DUAL_BANK = 1'b0,
  parameter int          KEY_LEN   = 15,
  parameter logic [8*KEY_LEN-1:0] KEY = "UNLOCK SEQUENCE",
  parameter logic [7:0]  RESP_BYTE = 8'h47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rnw,
  input  logic              cpu_ce_n,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en,
  output logic              resp_valid,
  output logic              resp_bit
);
  localparam int BANK_W = ROM_AW - 14;

  logic wr_acc, rd_acc, guard_hit;
  lock_state_t lock_state;
  logic lock_open, lock_dead, resp_phase;
  logic mismatch_evt, key_done_evt, resp_last_evt;
  logic [BANK_W-1:0] hi_bank, lo_bank;

  assign wr_acc    = !cpu_ce_n && !cpu_rnw;
  assign rd_acc    = !cpu_ce_n &&  cpu_rnw;
  assign guard_hit = in_guard(cpu_addr);

  cart_key_seq #(
    .KEY_LEN(KEY_LEN), .KEY(KEY), .RESP_BYTE(RESP_BYTE)
  ) u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_acc && guard_hit),
    .rd_stb(rd_acc && guard_hit),
    .key_din(cpu_wdata[2]),
    .state(lock_state),
    .resp_valid(resp_valid),
    .resp_bit(resp_bit),
    .mismatch_evt(mismatch_evt),
    .key_done_evt(key_done_evt),
    .resp_last_evt(resp_last_evt)
  );

  assign lock_open  = (lock_state == ST_OPEN);
  assign lock_dead  = (lock_state == ST_DEAD);
  assign resp_phase = (lock_state == ST_RESP);

  cart_bank_file #(.BANK_W(BANK_W), .DUAL_BANK(DUAL_BANK)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_acc),
    .addr_top(cpu_addr[15:13]),
    .wdata(cpu_wdata[BANK_W-1:0]),
    .hi_bank(hi_bank),
    .lo_bank(lo_bank)
  );

  cart_addr_xlat #(.ROM_AW(ROM_AW)) u_xlat (
    .addr(cpu_addr),
    .rd_stb(rd_acc),
    .open(lock_open),
    .hi_bank(hi_bank),
    .lo_bank(lo_bank),
    .rom_addr(rom_addr),
    .rom_en(rom_en)
  );

endmodule

// File: rtl/cart_guard_mapper_chk.sv
module cart_guard_mapper_chk #(
  parameter int ROM_AW = 17,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rnw,
  input logic              cpu_ce_n,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_en,
  input logic              resp_valid,
  input logic              lock_open,
  input logic              lock_dead,
  input logic              resp_phase,
  input logic              mismatch_evt,
  input logic              key_done_evt,
  input logic              resp_last_evt,
  input logic [BANK_W-1:0] hi_bank
);
  // R5
  rom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> lock_open);

  // R4
  resp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_phase && !rom_en));

  // R4
  key_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_done_evt |=> resp_phase);

  // R5
  open_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last_evt |=> lock_open);

  // R3
  mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> lock_dead);

  // R3
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_dead |=> (lock_dead && !rom_en && !resp_valid));

  // R7
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ce_n && !cpu_rnw && cpu_addr[15:13] == 3'b110)
      |=> hi_bank == $past(cpu_wdata[BANK_W-1:0]));

  // R6
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> rom_addr[12:0] == cpu_addr[12:0]);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce_n |-> (!rom_en && !resp_valid));

endmodule

bind cart_guard_mapper cart_guard_mapper_chk #(.ROM_AW(ROM_AW), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rnw(cpu_rnw), .cpu_ce_n(cpu_ce_n), .rom_addr(rom_addr), .rom_en(rom_en),
  .resp_valid(resp_valid), .lock_open(lock_open), .lock_dead(lock_dead),
  .resp_phase(resp_phase), .mismatch_evt(mismatch_evt), .key_done_evt(key_done_evt),
  .resp_last_evt(resp_last_evt), .hi_bank(hi_bank)
);

// File: tb/tb_cart_guard_mapper.sv
module tb_cart_guard_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic cpu_rnw = 1'b1;
  logic cpu_ce_n = 1'b1;
  logic [16:0] rom_addr, rom_addr2;
  logic rom_en, rom_en2, resp_valid, resp_valid2, resp_bit, resp_bit2;

  always #2 clk = ~clk;

  cart_guard_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_ce_n(cpu_ce_n), .rom_addr(rom_addr), .rom_en(rom_en),
    .resp_valid(resp_valid), .resp_bit(resp_bit));

  cart_guard_mapper #(.DUAL_BANK(1'b1)) dut_dual (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_ce_n(cpu_ce_n), .rom_addr(rom_addr2), .rom_en(rom_en2),
    .resp_valid(resp_valid2), .resp_bit(resp_bit2));

  localparam logic [119:0] KEYSTR = "UNLOCK SEQUENCE";
  localparam logic [7:0]   ANSWER = 8'h47;

  // {rnw, addr, wdata, exp_en, exp_addr}; banks start at 0, single-bank dut.
  localparam int NV = 14;
  localparam logic [42:0] TBL [NV] = '{
    {1'b1, 16'h6000, 8'h00, 1'b1, 17'h00000},
    {1'b1, 16'h9FFF, 8'h00, 1'b1, 17'h03FFF},
    {1'b1, 16'hA000, 8'h00, 1'b1, 17'h00000},
    {1'b0, 16'hC000, 8'h05, 1'b0, 17'h00000},
    {1'b1, 16'hA123, 8'h00, 1'b1, 17'h14123},
    {1'b1, 16'hDFFF, 8'h00, 1'b1, 17'h17FFF},
    {1'b0, 16'hA000, 8'h02, 1'b0, 17'h00000},
    {1'b1, 16'hB000, 8'h00, 1'b1, 17'h15000},
    {1'b0, 16'h8000, 8'h03, 1'b0, 17'h00000},
    {1'b1, 16'h8000, 8'h00, 1'b1, 17'h02000},
    {1'b1, 16'h5FFF, 8'h00, 1'b0, 17'h00000},
    {1'b1, 16'hE000, 8'h00, 1'b0, 17'h00000},
    {1'b0, 16'hDABC, 8'hF7, 1'b0, 17'h00000},
    {1'b1, 16'hC000, 8'h00, 1'b1, 17'h1E000}
  };

  int n_chk = 0;
  int n_fail = 0;
  logic c_en, c_en2, c_rv, c_rv2, c_rb;
  logic [16:0] c_addr, c_addr2;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic sel, input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_ce_n = ~sel; cpu_rnw = rd; cpu_addr = a; cpu_wdata = d;
    #1;
    c_en = rom_en; c_addr = rom_addr; c_rv = resp_valid; c_rb = resp_bit;
    c_en2 = rom_en2; c_addr2 = rom_addr2; c_rv2 = resp_valid2;
    @(posedge clk);
    #1;
    cpu_ce_n = 1'b1; cpu_rnw = 1'b1;
  endtask

  function automatic logic key_bit(input int n);
    int ch = n / 9;
    int b = n % 9;
    if (b == 8) return 1'b0;
    return KEYSTR[119 - 8*ch - b];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // flip_at < 0 sends the correct key
  task automatic send_key(input int flip_at);
    for (int n = 0; n < 135; n++) begin
      logic b;
      b = key_bit(n);
      if (n == flip_at) b = ~b;
      bus(1'b1, 1'b0, 16'h6000 + 16'(n*37), {5'b10101, b, 2'b10});
      if (n == 60) begin
        bus(1'b1, 1'b1, 16'h6000, 8'h00);
        check("R2 read mid-key resp_valid", 32'(c_rv), 0);
        check("R2 read mid-key rom_en", 32'(c_en), 0);
        bus(1'b0, 1'b0, 16'h7000, {5'b0, ~key_bit(61), 2'b0});
      end
      if (n == 133) begin
        bus(1'b1, 1'b1, 16'h6000, 8'h00);
        check("R5 rom_en before key end", 32'(c_en), 0);
      end
    end
  endtask

  task automatic get_answer(input logic expect_resp);
    for (int i = 0; i < 8; i++) begin
      bus(1'b1, 1'b1, 16'h6000 + 16'(i), 8'h00);
      check("R4 resp_valid", 32'(c_rv), 32'(expect_resp));
      if (expect_resp) check("R4 resp_bit", 32'(c_rb), 32'(ANSWER[7-i]));
      check("R5 rom_en during response", 32'(c_en), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    bus(1'b1, 1'b1, 16'h6000, 8'h00);
    check("R1 rom_en after reset", 32'(c_en), 0);
    check("R1 resp_valid after reset", 32'(c_rv), 0);

    // R2 R4 R5 full unlock
    send_key(-1);
    get_answer(1'b1);
    bus(1'b1, 1'b1, 16'h6000, 8'h00);
    check("R5 rom_en after eighth read", 32'(c_en), 1);

    // R9 deselected cycles
    bus(1'b0, 1'b1, 16'h6000, 8'h00);
    check("R9 rom_en with ce_n high", 32'(c_en), 0);
    bus(1'b0, 1'b0, 16'hC000, 8'h06);

    // R6 R7 R8 table
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = TBL[i];
      bus(1'b1, v[42], v[41:26], v[25:18]);
      if (v[42]) begin
        check("R5 R6 table rom_en", 32'(c_en), 32'(v[17]));
        if (v[17]) check("R6 R7 R8 R9 table rom_addr", 32'(c_addr), 32'(v[16:0]));
      end
    end

    // R1 R3 wrong key bit
    do_reset();
    send_key(20);
    get_answer(1'b0);
    bus(1'b1, 1'b1, 16'h6000, 8'h00);
    check("R3 rom_en after bad key", 32'(c_en), 0);
    bus(1'b1, 1'b1, 16'hA000, 8'h00);
    check("R3 rom_en upper after bad key", 32'(c_en), 0);

    // wrong trailing zero
    do_reset();
    send_key(8);
    get_answer(1'b0);

    // R1 bank reset and R8 dual variant
    do_reset();
    send_key(-1);
    get_answer(1'b1);
    bus(1'b1, 1'b1, 16'hA000, 8'h00);
    check("R1 upper bank zero after reset", 32'(c_addr), 32'h00000);
    bus(1'b1, 1'b1, 16'h6000, 8'h00);
    check("R1 dual lower bank zero after reset", 32'(c_addr2), 32'h00000);
    bus(1'b1, 1'b0, 16'h8000, 8'h03);
    bus(1'b1, 1'b1, 16'h6000, 8'h00);
    check("R8 single lower fixed", 32'(c_addr), 32'h00000);
    check("R8 dual lower selected", 32'(c_addr2), 32'h0C000);
    check("R8 dual rom_en", 32'(c_en2), 1);
    bus(1'b1, 1'b1, 16'h9FFF, 8'h00);
    check("R8 dual lower top", 32'(c_addr2), 32'h0FFFF);
    bus(1'b1, 1'b0, 16'hD000, 8'h01);
    bus(1'b1, 1'b1, 16'hA001, 8'h00);
    check("R7 dual upper load", 32'(c_addr2), 32'h04001);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule